// File: doc/BRIEF.md
# Control Endpoint Mode and Status Register

This block holds the mode and status byte of a USB device's bidirectional control endpoint. Two agents share the byte. The CPU side has a read strobe, a write strobe and an 8-bit data bus. The serial interface engine (SIE) side signals the end of a token phase together with the token kind, signals an ACK-terminated transaction, and raises a level while the data packet of a SETUP transaction is in flight. The byte carries a 4-bit response mode, an ACK flag and three flags that report which token arrived.

When the SIE changes any of the lower seven bits, the register stops accepting CPU writes to those bits. It accepts them again only after the CPU has read the register. Firmware therefore writes and then reads back to confirm that its write took effect. The SETUP flag follows a clear-on-write rule, and only the SIE can set it. While that flag is set, or the SIE is holding it high, the block raises an output that stops the CPU from writing the endpoint FIFO. A parameter turns locking off, so the same logic can serve as an ordinary endpoint mode register.

Top module: `ctl_ep_mode_reg`

## Requirements
- R1: After a synchronous reset, the read data, `lock_flag` and `fifo_wr_block` are all 0.
- R2: `cpu_rdata` shows the stored byte as {setup[7], in_rx[6], out_rx[5], ack[4], mode[3:0]}. An accepted CPU write loads bits 6:0 from `cpu_wdata`, and the new value is visible in the next cycle.
- R3: When `sie_tok_end` is high, the code on `sie_tok_kind` sets one flag: 01 sets bit 5 (OUT), 10 sets bit 6 (IN), and 11 sets bit 7 (SETUP). The other bits keep their values. Code 00 changes nothing.
- R4: `sie_ack` high sets bit 4 in the next cycle.
- R5: An SIE update is `sie_tok_end` with a nonzero kind, or `sie_ack`. It sets `lock_flag` in the next cycle. While `lock_flag` is 1, CPU writes leave bits 6:0 unchanged.
- R6: A CPU read clears `lock_flag` in the next cycle. If a read and an SIE update fall in the same cycle, the lock stays set, and the read returns the byte as it was before the update.
- R7: If an SIE update and a CPU write fall in the same cycle, the SIE update wins: the written bits 6:0 are discarded and the lock becomes set.
- R8: Any CPU write clears bit 7, whatever the data and whatever the lock state. This does not happen when `sie_setup_hold` is high or a SETUP token ends in the same cycle.
- R9: While `sie_setup_hold` is high, bit 7 reads 1 from the next cycle onward.
- R10: `fifo_wr_block` is high whenever bit 7 is set or `sie_setup_hold` is high.
- R11: With `LOCK_EN` = 0, `lock_flag` stays 0 and CPU writes to bits 6:0 are always accepted, except in the case of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | CPU read strobe, clears the lock |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Stored byte |
| sie_tok_end | input | 1 | End of a token phase |
| sie_tok_kind | input | 2 | Token kind: 00 none, 01 OUT, 10 IN, 11 SETUP |
| sie_ack | input | 1 | Transaction finished with an ACK |
| sie_setup_hold | input | 1 | SETUP data packet in flight, forces bit 7 |
| fifo_wr_block | output | 1 | Blocks CPU writes to the endpoint FIFO |
| lock_flag | output | 1 | CPU writes to bits 6:0 are currently ignored |

## Verification
The assertions assume that reset is applied before anything else happens, and that the strobes are either held stable or changed only away from the clock edge. Every input combination is legal, including a read, a write, a token end and an ACK all in one cycle, so no assertion depends on the agents taking turns. The random stimulus draws every strobe independently each cycle, which produces these collisions often. It keeps `sie_setup_hold` high for bursts rather than single cycles, which matches how a data packet behaves.

// File: rtl/ctlep_pkg.sv
package ctlep_pkg;
    localparam int MODE_W = 4;
    localparam int REG_W  = MODE_W + 4;

    typedef enum logic [1:0] {
        TOK_NONE  = 2'b00,
        TOK_OUT   = 2'b01,
        TOK_IN    = 2'b10,
        TOK_SETUP = 2'b11
    } tok_kind_e;

    typedef struct packed {
        logic              setup;
        logic              in_rx;
        logic              out_rx;
        logic              ack;
        logic [MODE_W-1:0] mode;
    } ep0_reg_t;

    function automatic logic sie_touches(logic tok_end, tok_kind_e kind, logic ack);
        return (tok_end && kind != TOK_NONE) || ack;
    endfunction
endpackage

// File: rtl/ctlep_lock.sv
module ctlep_lock #(
    parameter bit LOCK_EN = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic sie_upd,
    input  logic cpu_rd,
    output logic locked
);
    generate
        if (LOCK_EN) begin : g_lock
            logic lk_q;
            always_ff @(posedge clk) begin
                if (rst)          lk_q <= 1'b0;
                else if (sie_upd) lk_q <= 1'b1;
                else if (cpu_rd)  lk_q <= 1'b0;
            end
            assign locked = lk_q;

            // R5
            lock_after_update_chk: assert property (@(posedge clk) disable iff (rst)
                sie_upd |=> locked);
            // R6
            read_unlocks_chk: assert property (@(posedge clk) disable iff (rst)
                cpu_rd && !sie_upd |=> !locked);
        end else begin : g_nolock
            assign locked = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/ctlep_regfile.sv
module ctlep_regfile
    import ctlep_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lock_i,
    input  logic                 sie_upd,
    input  logic                 cpu_wr,
    input  logic [REG_W-1:0]     cpu_wdata,
    input  logic                 tok_end,
    input  tok_kind_e            tok_kind,
    input  logic                 sie_ack,
    input  logic                 setup_hold,
    output ep0_reg_t             q
);
    ep0_reg_t d;
    logic     low_wr_ok;

    assign low_wr_ok = cpu_wr && !lock_i && !sie_upd;

    always_comb begin
        d = q;
        if (low_wr_ok) begin
            d.in_rx  = cpu_wdata[REG_W-2];
            d.out_rx = cpu_wdata[REG_W-3];
            d.ack    = cpu_wdata[REG_W-4];
            d.mode   = cpu_wdata[MODE_W-1:0];
        end
        if (cpu_wr) d.setup = 1'b0;
        if (tok_end) begin
            case (tok_kind)
                TOK_OUT:   d.out_rx = 1'b1;
                TOK_IN:    d.in_rx  = 1'b1;
                TOK_SETUP: d.setup  = 1'b1;
                default:   ;
            endcase
        end
        if (sie_ack)    d.ack   = 1'b1;
        if (setup_hold) d.setup = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // R5
    locked_wr_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        lock_i && cpu_wr && !sie_upd |=> q[REG_W-2:0] == $past(q[REG_W-2:0]));
    // R4
    ack_sets_chk: assert property (@(posedge clk) disable iff (rst)
        sie_ack |=> q.ack);
    // R9
    hold_forces_setup_chk: assert property (@(posedge clk) disable iff (rst)
        setup_hold |=> q.setup);
    // R8
    write_clears_setup_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_wr && !setup_hold && !(tok_end && tok_kind == TOK_SETUP) |=> !q.setup);
endmodule

// File: rtl/ctl_ep_mode_reg.sv
module ctl_ep_mode_reg
    import ctlep_pkg::*;
#(
    parameter bit LOCK_EN = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_rd,
    input  logic       cpu_wr,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    input  logic       sie_tok_end,
    input  logic [1:0] sie_tok_kind,
    input  logic       sie_ack,
    input  logic       sie_setup_hold,
    output logic       fifo_wr_block,
    output logic       lock_flag
);
    tok_kind_e kind;
    logic      sie_upd;
    logic      locked;
    ep0_reg_t  q;

    assign kind    = tok_kind_e'(sie_tok_kind);
    assign sie_upd = sie_touches(sie_tok_end, kind, sie_ack);

    ctlep_lock #(.LOCK_EN(LOCK_EN)) u_lock (
        .clk     (clk),
        .rst     (rst),
        .sie_upd (sie_upd),
        .cpu_rd  (cpu_rd),
        .locked  (locked)
    );

    ctlep_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .lock_i     (locked),
        .sie_upd    (sie_upd),
        .cpu_wr     (cpu_wr),
        .cpu_wdata  (cpu_wdata),
        .tok_end    (sie_tok_end),
        .tok_kind   (kind),
        .sie_ack    (sie_ack),
        .setup_hold (sie_setup_hold),
        .q          (q)
    );

    assign cpu_rdata     = q;
    assign lock_flag     = locked;
    assign fifo_wr_block = q.setup || sie_setup_hold;

    // R10
    fifo_block_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $past(sie_setup_hold) |-> fifo_wr_block);
    // R11
    no_lock_variant_chk: assert property (@(posedge clk) disable iff (rst)
        !LOCK_EN |-> !lock_flag);
endmodule

// File: tb/sim_ctl_ep_mode_reg.sv
module sim_ctl_ep_mode_reg;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd = 0, wr = 0, te = 0, ack = 0, hold = 0;
    logic [7:0] wd = 0;
    logic [1:0] kind = 0;
    logic [7:0] rdata0, rdata1;
    logic       blk0, blk1, lk0, lk1;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] m0_q = 0, m1_q = 0;
    logic       m0_lk = 0, m1_lk = 0;

    always #10 clk = ~clk;

    ctl_ep_mode_reg #(.LOCK_EN(1'b1)) u0 (
        .clk(clk), .rst(rst), .cpu_rd(rd), .cpu_wr(wr), .cpu_wdata(wd),
        .cpu_rdata(rdata0), .sie_tok_end(te), .sie_tok_kind(kind),
        .sie_ack(ack), .sie_setup_hold(hold), .fifo_wr_block(blk0),
        .lock_flag(lk0));

    ctl_ep_mode_reg #(.LOCK_EN(1'b0)) u1 (
        .clk(clk), .rst(rst), .cpu_rd(rd), .cpu_wr(wr), .cpu_wdata(wd),
        .cpu_rdata(rdata1), .sie_tok_end(te), .sie_tok_kind(kind),
        .sie_ack(ack), .sie_setup_hold(hold), .fifo_wr_block(blk1),
        .lock_flag(lk1));

    // Expected next state, computed from R2..R9 and R11; returns {lock, byte}
    function automatic logic [8:0] nxt(input logic [7:0] q, input logic lk, input bit len,
                                       input logic r, input logic w, input logic [7:0] d,
                                       input logic t, input logic [1:0] k,
                                       input logic a, input logic h);
        logic [7:0] n = q;
        logic       upd = (t && k != 2'b00) || a;
        logic       nl;
        if (w && !upd && !(len && lk)) n[6:0] = d[6:0];
        if (w) n[7] = 1'b0;
        if (t && k == 2'b01) n[5] = 1'b1;
        if (t && k == 2'b10) n[6] = 1'b1;
        if (t && k == 2'b11) n[7] = 1'b1;
        if (a) n[4] = 1'b1;
        if (h) n[7] = 1'b1;
        nl = len && (upd || (lk && !r));
        return {nl, n};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic w, input logic [7:0] d,
                        input logic t, input logic [1:0] k,
                        input logic a, input logic h, input string tag);
        logic [8:0] n0, n1;
        @(negedge clk);
        rd = r; wr = w; wd = d; te = t; kind = k; ack = a; hold = h;
        #1;
        chk({tag, " R2 rdata"}, rdata0, m0_q);
        chk({tag, " R5 lock"}, {7'd0, lk0}, {7'd0, m0_lk});
        chk({tag, " R10 block"}, {7'd0, blk0}, {7'd0, m0_q[7] | h});
        chk({tag, " R11 rdata"}, rdata1, m1_q);
        chk({tag, " R11 lock"}, {7'd0, lk1}, 8'd0);
        n0 = nxt(m0_q, m0_lk, 1'b1, r, w, d, t, k, a, h);
        n1 = nxt(m1_q, m1_lk, 1'b0, r, w, d, t, k, a, h);
        {m0_lk, m0_q} = n0;
        {m1_lk, m1_q} = n1;
    endtask

    task automatic idle(input string tag);
        step(0, 0, 8'h00, 0, 2'b00, 0, 0, tag);
    endtask

    initial begin : watchdog
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int unsigned seed = 32'h5eed_0042;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        idle("R1 reset");
        // R2: unlocked write, then read back
        step(0, 1, 8'hA5, 0, 2'b00, 0, 0, "R2 write");
        idle("R2 readback");
        // R3: each token kind, and kind 00 (no change, no lock)
        step(0, 0, 8'h00, 1, 2'b00, 0, 0, "R3 none");
        idle("R3 none after");
        step(0, 0, 8'h00, 1, 2'b01, 0, 0, "R3 out");
        step(1, 0, 8'h00, 0, 2'b00, 0, 0, "R3 read");
        step(0, 0, 8'h00, 1, 2'b10, 0, 0, "R3 in");
        // R5: locked write ignored for bits 6:0, R8 still clears bit 7
        step(0, 1, 8'h7F, 0, 2'b00, 0, 0, "R5 locked write");
        idle("R5 check");
        // R6: read + update same cycle keeps lock, returns old byte
        step(1, 0, 8'h00, 0, 2'b00, 1, 0, "R6 read+ack");
        step(0, 1, 8'h00, 0, 2'b00, 0, 0, "R6 still locked");
        step(1, 0, 8'h00, 0, 2'b00, 0, 0, "R6 unlock read");
        // R4 and R7: ack with a simultaneous write
        step(0, 1, 8'h00, 0, 2'b00, 1, 0, "R7 collide");
        step(1, 0, 8'h00, 0, 2'b00, 0, 0, "R4 ack set");
        // R9: hold bursts, R8 write during hold leaves bit 7 set
        step(0, 0, 8'h00, 0, 2'b00, 0, 1, "R9 hold");
        step(0, 1, 8'hFF, 0, 2'b00, 0, 1, "R8 write in hold");
        step(0, 0, 8'h00, 1, 2'b11, 0, 0, "R3 setup end");
        step(0, 1, 8'h80, 1, 2'b11, 0, 0, "R8 write vs setup");
        step(1, 1, 8'h00, 0, 2'b00, 0, 0, "R8 write clears");
        idle("R8 after");
        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic h;
            h = ($urandom % 16 == 0) ? ~hold : hold;
            step(($urandom % 4) == 0, ($urandom % 3) == 0, 8'($urandom),
                 ($urandom % 5) == 0, 2'($urandom), ($urandom % 8) == 0, h,
                 "rand");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule